// File: doc/BRIEF.md
# Thermal Shutdown Supervisor

This block watches up to four on-die temperature sensors without software help. While its run bit is set it walks the enabled sensor channels in ascending order. For each channel it asks an external converter for a 10-bit reading over a request/acknowledge handshake. It keeps the newest reading of every channel and compares it against two per-channel limits: a warning limit and a shutdown limit. The readings can be inverted first, for sensors whose code falls as they get hotter.

A crossing only counts once it has held for a programmed number of back-to-back readings. The warning limit and the shutdown limit each have their own count. A confirmed warning sets a sticky pending bit, which raises the interrupt line when that channel's interrupt is enabled. A confirmed shutdown latches per channel until reset. It drives two shutdown lines, one toward the reset controller and one toward a package pin. Each line has its own per-channel routing mask, and both share a programmable active level.

After a scan in which any reading crossed either limit, the block waits a shorter interval before the next scan. Otherwise it waits the normal interval.

Top module: `thermal_guard`

## Requirements
- R1: After reset adc_req, irq, shut_rst and shut_pin are low, the control word at 0x00 reads 0x4, the pending word at 0x08 reads 0, and every limit register reads 1023.
- R2: No conversion is requested while run (bit 0 of 0x00) is clear. While it is set, each scan requests the channels whose enable bit (bits 4+i of 0x00) is set, in ascending index order, with adc_chan equal to the index.
- R3: The register at 0x20+4*i holds the raw code last returned for channel i and stays 0 for a channel that has never been read.
- R4: The compared value is the raw code when the invert bit (bit 1 of 0x00) is clear, and 1023 minus the code when it is set. A reading crosses a limit only when the compared value is strictly greater than that limit (warning limit at 0x30+4*i, shutdown limit at 0x40+4*i).
- R5: The pending bit i (bit i of 0x08) is set on the reading where the run of consecutive warning crossings of channel i reaches the count at 0x14. Any non-crossing reading restarts the run. irq is high when a pending bit is set whose enable (bit i of 0x04) is set.
- R6: Writing 1 to a pending bit clears it and writing 0 leaves it. If a new warning event arrives in the same cycle as the clearing write, the bit stays set.
- R7: Shutdown for channel i latches on the reading where its own run of consecutive shutdown crossings reaches the count at 0x18. It then stays latched until reset whatever later readings show, and reads back in bit 4+i of 0x08.
- R8: shut_pin is active when a latched channel has its pin enable (bit 4+i of 0x04) set. shut_rst is active when a latched channel has its reset enable (bit 8+i of 0x04) set.
- R9: The level bit (bit 2 of 0x00) set makes both shutdown lines active high. With the bit clear both lines are active low.
- R10: The wait after a scan is set by the normal interval at 0x0C. If any reading of that scan crossed either limit, the wait is set by the hot interval at 0x10 instead. The spacing between scans therefore differs by exactly the difference of the two values.
- R11: Once raised, adc_req stays high with adc_chan unchanged until adc_ack is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address, used for both reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| adc_req | output | 1 | Conversion request |
| adc_chan | output | 2 | Channel being converted |
| adc_ack | input | 1 | Converter acknowledge; adc_code is valid with it |
| adc_code | input | 10 | Converted code |
| irq | output | 1 | Enabled warning pending |
| shut_rst | output | 1 | Shutdown toward the reset controller, programmable level |
| shut_pin | output | 1 | Shutdown toward the pin, programmable level |

## Verification
Two functions can land on the same edge: a warning event setting a pending bit, and a software write clearing that same bit. The bench provokes this by driving the write-one-to-clear strobe on the very negative edge where its converter model raises adc_ack for a crossing reading, so the design sees both at one rising edge. The pending bit is then read back, and it must still be set. A plain clear issued between readings must leave it at zero.

// File: rtl/thermal_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the thermal shutdown supervisor: register
// addresses and the scan sequencer state type.
// Assumes byte addressing with 32-bit aligned registers.
package thermal_pkg;

    localparam logic [7:0] A_CTRL   = 8'h00;  // run, invert, level, channel enables
    localparam logic [7:0] A_ROUTE  = 8'h04;  // irq enables, pin enables, reset enables
    localparam logic [7:0] A_PEND   = 8'h08;  // pending (W1C) and latched shutdown
    localparam logic [7:0] A_NPER   = 8'h0C;  // normal interval
    localparam logic [7:0] A_HPER   = 8'h10;  // hot interval
    localparam logic [7:0] A_IDEB   = 8'h14;  // warning debounce count
    localparam logic [7:0] A_SDEB   = 8'h18;  // shutdown debounce count

    localparam logic [3:0] PG_DATA  = 4'h2;   // 0x20 + 4*i
    localparam logic [3:0] PG_ITHR  = 4'h3;   // 0x30 + 4*i
    localparam logic [3:0] PG_STHR  = 4'h4;   // 0x40 + 4*i

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_GAP,
        SQ_SCAN,
        SQ_REQ
    } seq_state_t;

endpackage

// File: rtl/thermal_regs.sv
`timescale 1ns/1ps
// Register file of the thermal supervisor. Holds configuration, the
// per-channel limits, the newest reading per channel and the sticky
// warning pending bits.
// Assumes 2 <= NCH <= 4 so that channel fields fit their nibble slots.
module thermal_regs
    import thermal_pkg::*;
#(
    parameter int          NCH      = 4,
    parameter int          CODE_W   = 10,
    parameter int          PER_W    = 20,
    parameter int          DEB_W    = 8,
    parameter int unsigned NORM_RST = 187500,
    parameter int unsigned HOT_RST  = 37500
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           reg_wr,
    input  logic [7:0]                     reg_addr,
    input  logic [31:0]                    reg_wdata,
    output logic [31:0]                    reg_rdata,
    input  logic                           smp_vld,
    input  logic [$clog2(NCH)-1:0]         smp_ch,
    input  logic [CODE_W-1:0]              smp_code,
    input  logic [NCH-1:0]                 irq_set,
    input  logic [NCH-1:0]                 shut_hit,
    output logic                           run,
    output logic                           invert,
    output logic                           lvl_high,
    output logic [NCH-1:0]                 ch_en,
    output logic [NCH-1:0]                 irq_en,
    output logic [NCH-1:0]                 pin_en,
    output logic [NCH-1:0]                 rst_en,
    output logic [PER_W-1:0]               per_norm,
    output logic [PER_W-1:0]               per_hot,
    output logic [DEB_W-1:0]               deb_irq,
    output logic [DEB_W-1:0]               deb_shut,
    output logic [NCH-1:0][CODE_W-1:0]     irq_thr,
    output logic [NCH-1:0][CODE_W-1:0]     shut_thr,
    output logic [NCH-1:0]                 pend
);

    localparam int CH_W = $clog2(NCH);

    logic [NCH-1:0][CODE_W-1:0] data_q;
    logic [1:0]                 slot;
    logic                       aligned;
    logic                       wr_pend;

    assign slot    = reg_addr[3:2];
    assign aligned = (reg_addr[1:0] == 2'b00);
    assign wr_pend = reg_wr && (reg_addr == A_PEND);

    // Scalar configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run      <= 1'b0;
            invert   <= 1'b0;
            lvl_high <= 1'b1;
            ch_en    <= '0;
            irq_en   <= '0;
            pin_en   <= '0;
            rst_en   <= '0;
            per_norm <= PER_W'(NORM_RST);
            per_hot  <= PER_W'(HOT_RST);
            deb_irq  <= DEB_W'(1);
            deb_shut <= DEB_W'(1);
        end else if (reg_wr) begin
            case (reg_addr)
                A_CTRL: begin
                    run      <= reg_wdata[0];
                    invert   <= reg_wdata[1];
                    lvl_high <= reg_wdata[2];
                    ch_en    <= reg_wdata[4 +: NCH];
                end
                A_ROUTE: begin
                    irq_en <= reg_wdata[0 +: NCH];
                    pin_en <= reg_wdata[4 +: NCH];
                    rst_en <= reg_wdata[8 +: NCH];
                end
                A_NPER:  per_norm <= reg_wdata[PER_W-1:0];
                A_HPER:  per_hot  <= reg_wdata[PER_W-1:0];
                A_IDEB:  deb_irq  <= reg_wdata[DEB_W-1:0];
                A_SDEB:  deb_shut <= reg_wdata[DEB_W-1:0];
                default: ;
            endcase
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic hit_slot;
        assign hit_slot = reg_wr && aligned && (slot == 2'(i));

        // Per-channel limits, reset to the top code so nothing crosses.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                irq_thr[i]  <= '1;
                shut_thr[i] <= '1;
            end else begin
                if (hit_slot && reg_addr[7:4] == PG_ITHR) irq_thr[i]  <= reg_wdata[CODE_W-1:0];
                if (hit_slot && reg_addr[7:4] == PG_STHR) shut_thr[i] <= reg_wdata[CODE_W-1:0];
            end
        end

        // Newest raw reading of this channel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_q[i] <= '0;
            end else if (smp_vld && smp_ch == CH_W'(i)) begin
                data_q[i] <= smp_code;
            end
        end

        // Sticky pending bit; a fresh event beats a simultaneous clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend[i] <= 1'b0;
            end else begin
                pend[i] <= irq_set[i] | (pend[i] & ~(wr_pend & reg_wdata[i]));
            end
        end
    end

    // Combinational read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: begin
                reg_rdata[0]       = run;
                reg_rdata[1]       = invert;
                reg_rdata[2]       = lvl_high;
                reg_rdata[4 +: NCH] = ch_en;
            end
            A_ROUTE: begin
                reg_rdata[0 +: NCH] = irq_en;
                reg_rdata[4 +: NCH] = pin_en;
                reg_rdata[8 +: NCH] = rst_en;
            end
            A_PEND: begin
                reg_rdata[0 +: NCH] = pend;
                reg_rdata[4 +: NCH] = shut_hit;
            end
            A_NPER: reg_rdata[PER_W-1:0] = per_norm;
            A_HPER: reg_rdata[PER_W-1:0] = per_hot;
            A_IDEB: reg_rdata[DEB_W-1:0] = deb_irq;
            A_SDEB: reg_rdata[DEB_W-1:0] = deb_shut;
            default: begin
                if (aligned && int'(slot) < NCH) begin
                    case (reg_addr[7:4])
                        PG_DATA: reg_rdata[CODE_W-1:0] = data_q[CH_W'(slot)];
                        PG_ITHR: reg_rdata[CODE_W-1:0] = irq_thr[CH_W'(slot)];
                        PG_STHR: reg_rdata[CODE_W-1:0] = shut_thr[CH_W'(slot)];
                        default: ;
                    endcase
                end
            end
        endcase
    end

    // R6: a clearing write with no concurrent event leaves the bit low.
    p_pend_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pend |=> ((pend & $past(reg_wdata[NCH-1:0] & ~irq_set)) == '0));

    // R6: an event always leaves its pending bit set.
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_set) |=> ((pend & $past(irq_set)) == $past(irq_set)));

endmodule

// File: rtl/thermal_seq.sv
`timescale 1ns/1ps
// Scan sequencer: waits the interval, then walks enabled channels in
// ascending order, holding one request per channel until acknowledged.
// The next interval is the hot one if any reading of the scan crossed.
// Assumes NCH >= 2 and that the converter eventually acknowledges.
module thermal_seq
    import thermal_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int PER_W = 20
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   run,
    input  logic [NCH-1:0]         ch_en,
    input  logic [PER_W-1:0]       per_norm,
    input  logic [PER_W-1:0]       per_hot,
    output logic                   adc_req,
    output logic [$clog2(NCH)-1:0] adc_chan,
    input  logic                   adc_ack,
    input  logic                   smp_hot,
    output logic                   smp_vld
);

    localparam int                CH_W = $clog2(NCH);
    localparam logic [CH_W-1:0]   LAST = CH_W'(NCH - 1);

    seq_state_t       state;
    logic [CH_W-1:0]  idx;
    logic [PER_W-1:0] timer;
    logic             hot_acc;
    logic             hot_now;

    assign adc_req  = (state == SQ_REQ);
    assign adc_chan = idx;
    assign smp_vld  = (state == SQ_REQ) && adc_ack;
    assign hot_now  = hot_acc | (smp_vld & smp_hot);

    // Scan state machine with interval countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SQ_IDLE;
            idx     <= '0;
            timer   <= '0;
            hot_acc <= 1'b0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (run) begin
                        state   <= SQ_SCAN;
                        idx     <= '0;
                        hot_acc <= 1'b0;
                    end
                end
                SQ_GAP: begin
                    if (!run) begin
                        state <= SQ_IDLE;
                    end else if (timer == '0) begin
                        state   <= SQ_SCAN;
                        idx     <= '0;
                        hot_acc <= 1'b0;
                    end else begin
                        timer <= timer - 1'b1;
                    end
                end
                SQ_SCAN: begin
                    if (!run) begin
                        state <= SQ_IDLE;
                    end else if (ch_en[idx]) begin
                        state <= SQ_REQ;
                    end else if (idx == LAST) begin
                        state <= SQ_GAP;
                        timer <= hot_now ? per_hot : per_norm;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                SQ_REQ: begin
                    if (adc_ack) begin
                        hot_acc <= hot_now;
                        if (idx == LAST) begin
                            state <= SQ_GAP;
                            timer <= hot_now ? per_hot : per_norm;
                        end else begin
                            state <= SQ_SCAN;
                            idx   <= idx + 1'b1;
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // R11: an unanswered request is held with the same channel.
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_req && !adc_ack) |=> (adc_req && $stable(adc_chan)));

    // R2: with run clear and no request open, none is raised.
    p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !adc_req) |=> !adc_req);

endmodule

// File: rtl/thermal_chan.sv
`timescale 1ns/1ps
// Per-channel evaluator: maps the code by sensor sense, compares it
// against both limits, runs the two debounce counts and latches shutdown.
// Assumes smp is a single-cycle strobe per reading of this channel.
module thermal_chan #(
    parameter int CODE_W = 10,
    parameter int DEB_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp,
    input  logic [CODE_W-1:0] code,
    input  logic              invert,
    input  logic [CODE_W-1:0] irq_thr,
    input  logic [CODE_W-1:0] shut_thr,
    input  logic [DEB_W-1:0]  deb_irq,
    input  logic [DEB_W-1:0]  deb_shut,
    output logic              over_any,
    output logic              irq_set,
    output logic              shut_hit
);

    localparam logic [CODE_W-1:0] CODE_MAX = '1;

    logic [CODE_W-1:0] adj;
    logic              over_irq;
    logic              over_shut;
    logic [DEB_W-1:0]  cnt_irq;
    logic [DEB_W-1:0]  cnt_shut;
    logic [DEB_W-1:0]  inc_irq;
    logic [DEB_W-1:0]  inc_shut;
    logic              shut_fire;

    assign adj       = invert ? (CODE_MAX - code) : code;
    assign over_irq  = adj > irq_thr;
    assign over_shut = adj > shut_thr;
    assign over_any  = over_irq | over_shut;
    assign inc_irq   = (cnt_irq  == '1) ? cnt_irq  : cnt_irq  + 1'b1;
    assign inc_shut  = (cnt_shut == '1) ? cnt_shut : cnt_shut + 1'b1;
    assign irq_set   = smp && over_irq  && (inc_irq  >= deb_irq);
    assign shut_fire = smp && over_shut && (inc_shut >= deb_shut);

    // Consecutive-crossing counters, restarted by any quiet reading.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_irq  <= '0;
            cnt_shut <= '0;
        end else if (smp) begin
            cnt_irq  <= over_irq  ? inc_irq  : '0;
            cnt_shut <= over_shut ? inc_shut : '0;
        end
    end

    // Shutdown latch, released only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shut_hit <= 1'b0;
        end else if (shut_fire) begin
            shut_hit <= 1'b1;
        end
    end

    // R7: latched shutdown never releases.
    p_shut_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        shut_hit |=> shut_hit);

    // R5: a quiet reading restarts the warning run.
    p_cnt_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (smp && !over_irq) |=> (cnt_irq == '0));

endmodule

// File: rtl/thermal_guard.sv
`timescale 1ns/1ps
// Top of the thermal shutdown supervisor: register file, scan sequencer
// and one evaluator per channel; drives irq and both shutdown lines.
// Assumes 2 <= NCH <= 4 and a converter obeying request/acknowledge.
module thermal_guard
    import thermal_pkg::*;
#(
    parameter int          NCH      = 4,
    parameter int          CODE_W   = 10,
    parameter int          PER_W    = 20,
    parameter int          DEB_W    = 8,
    parameter int unsigned NORM_RST = 187500,
    parameter int unsigned HOT_RST  = 37500
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic [7:0]             reg_addr,
    input  logic [31:0]            reg_wdata,
    output logic [31:0]            reg_rdata,
    output logic                   adc_req,
    output logic [$clog2(NCH)-1:0] adc_chan,
    input  logic                   adc_ack,
    input  logic [CODE_W-1:0]      adc_code,
    output logic                   irq,
    output logic                   shut_rst,
    output logic                   shut_pin
);

    localparam int CH_W = $clog2(NCH);

    logic                       run, invert, lvl_high;
    logic [NCH-1:0]             ch_en, irq_en, pin_en, rst_en, pend;
    logic [PER_W-1:0]           per_norm, per_hot;
    logic [DEB_W-1:0]           deb_irq, deb_shut;
    logic [NCH-1:0][CODE_W-1:0] irq_thr, shut_thr;
    logic [NCH-1:0]             irq_set, shut_hit, over_any;
    logic                       smp_vld, smp_hot;
    logic                       act_rst, act_pin;

    thermal_regs #(
        .NCH(NCH), .CODE_W(CODE_W), .PER_W(PER_W), .DEB_W(DEB_W),
        .NORM_RST(NORM_RST), .HOT_RST(HOT_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .smp_vld(smp_vld), .smp_ch(adc_chan), .smp_code(adc_code),
        .irq_set(irq_set), .shut_hit(shut_hit),
        .run(run), .invert(invert), .lvl_high(lvl_high), .ch_en(ch_en),
        .irq_en(irq_en), .pin_en(pin_en), .rst_en(rst_en),
        .per_norm(per_norm), .per_hot(per_hot),
        .deb_irq(deb_irq), .deb_shut(deb_shut),
        .irq_thr(irq_thr), .shut_thr(shut_thr), .pend(pend)
    );

    thermal_seq #(.NCH(NCH), .PER_W(PER_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .run(run), .ch_en(ch_en),
        .per_norm(per_norm), .per_hot(per_hot),
        .adc_req(adc_req), .adc_chan(adc_chan), .adc_ack(adc_ack),
        .smp_hot(smp_hot), .smp_vld(smp_vld)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_eval
        thermal_chan #(.CODE_W(CODE_W), .DEB_W(DEB_W)) u_chan (
            .clk(clk), .rst_n(rst_n),
            .smp(smp_vld && adc_chan == CH_W'(i)),
            .code(adc_code), .invert(invert),
            .irq_thr(irq_thr[i]), .shut_thr(shut_thr[i]),
            .deb_irq(deb_irq), .deb_shut(deb_shut),
            .over_any(over_any[i]), .irq_set(irq_set[i]), .shut_hit(shut_hit[i])
        );
    end

    // Crossing flag of the channel currently being read.
    assign smp_hot = over_any[adc_chan];

    // Output routing and active level.
    assign act_rst  = |(shut_hit & rst_en);
    assign act_pin  = |(shut_hit & pin_en);
    assign shut_rst = lvl_high ? act_rst : ~act_rst;
    assign shut_pin = lvl_high ? act_pin : ~act_pin;
    assign irq      = |(pend & irq_en);

    // R9: an active reset-path shutdown shows the programmed level.
    p_level_rst_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|(shut_hit & rst_en)) |-> (shut_rst == lvl_high));

    // R8: with nothing latched both lines sit at the inactive level.
    p_idle_lines_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (shut_hit == '0) |-> (shut_rst == !lvl_high && shut_pin == !lvl_high));

endmodule

// File: tb/tb_thermal_guard.sv
`timescale 1ns/1ps
module tb_thermal_guard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        adc_req;
    logic [1:0]  adc_chan;
    logic        adc_ack = 1'b0;
    logic [9:0]  adc_code = '0;
    logic        irq, shut_rst, shut_pin;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    int code_q [4];
    int chlog [16];
    int n_smp = 0, wcnt = 0, ack_delay = 0;
    int req_t_last = 0, req_t_prev = 0;
    int hold_ch = 0;
    bit req_prev = 0, clash = 0, clash_on = 0;

    always #2.5 clk = ~clk;

    thermal_guard dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .adc_req(adc_req),
        .adc_chan(adc_chan), .adc_ack(adc_ack), .adc_code(adc_code),
        .irq(irq), .shut_rst(shut_rst), .shut_pin(shut_pin)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Converter model: answers requests after ack_delay cycles.
    always @(negedge clk) begin
        if (!rst_n) begin
            adc_ack = 0; wcnt = 0; req_prev = 0;
        end else begin
            if (adc_ack) begin
                adc_ack = 0;
                if (clash_on) begin reg_wr = 0; clash_on = 0; end
            end else if (adc_req) begin
                if (!req_prev) begin
                    req_t_prev = req_t_last; req_t_last = cyc; hold_ch = adc_chan;
                end else if (ack_delay > 0) begin
                    chk("R11 channel stable", adc_chan, hold_ch);
                end
                if (wcnt < ack_delay) wcnt++;
                else begin
                    adc_ack = 1; wcnt = 0;
                    adc_code = 10'(code_q[adc_chan]);
                    chlog[n_smp % 16] = adc_chan;
                    n_smp++;
                    if (clash) begin
                        reg_wr = 1; reg_addr = 8'h08; reg_wdata = 32'h1;
                        clash = 0; clash_on = 1;
                    end
                end
            end else if (wcnt != 0) begin
                chk("R11 request withdrawn", 0, 1);
                wcnt = 0;
            end
            req_prev = adc_req;
        end
    end

    // Cycle count and watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic wreg(input logic [7:0] a, input int d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rreg(input logic [7:0] a, output int v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_smp(input int n);
        int t;
        t = n_smp + n;
        while (n_smp < t) @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    initial begin
        int v, base, k, sp_cold, sp_hot;
        for (int i = 0; i < 4; i++) code_q[i] = 0;
        do_reset();

        // R1: reset state
        chk("R1 adc_req", adc_req, 0);
        chk("R1 irq", irq, 0);
        chk("R1 shut_rst", shut_rst, 0);
        chk("R1 shut_pin", shut_pin, 0);
        rreg(8'h00, v); chk("R1 control", v, 4);
        rreg(8'h08, v); chk("R1 pending", v, 0);
        for (int i = 0; i < 4; i++) begin
            rreg(8'(8'h30 + 4*i), v); chk("R1 warn limit", v, 1023);
            rreg(8'(8'h40 + 4*i), v); chk("R1 shut limit", v, 1023);
        end

        // R2: no request while run clear
        wreg(8'h0C, 40);
        wreg(8'h00, 32'hF4);
        repeat (80) @(negedge clk);
        chk("R2 quiet with run clear", n_smp, 0);

        // R2/R3: every enable mask, order and stored data
        for (int m = 1; m < 16; m++) begin
            int exp_list [4];
            int cnt;
            do_reset();
            cnt = 0;
            for (int i = 0; i < 4; i++) begin
                code_q[i] = 100 + 37*i + m;
                if (m[i]) begin exp_list[cnt] = i; cnt++; end
            end
            base = n_smp;
            wreg(8'h0C, 200); wreg(8'h10, 200);
            wreg(8'h00, (m << 4) | 5);
            wait_smp(cnt);
            for (int j = 0; j < cnt; j++)
                chk("R2 scan order", chlog[(base + j) % 16], exp_list[j]);
            for (int i = 0; i < 4; i++) begin
                rreg(8'(8'h20 + 4*i), v);
                chk("R3 data register", v, m[i] ? code_q[i] : 0);
            end
        end

        // R4/R5: limit boundary sweep in both code senses
        for (int inv = 0; inv < 2; inv++) begin
            for (int d = -2; d <= 2; d++) begin
                do_reset();
                code_q[0] = inv ? 1023 - (600 + d) : 600 + d;
                wreg(8'h30, 600); wreg(8'h14, 1);
                wreg(8'h0C, 20); wreg(8'h10, 20); wreg(8'h04, 1);
                wreg(8'h00, 32'h15 | (inv << 1));
                wait_smp(1);
                chk("R4 strict compare irq", irq, d > 0 ? 1 : 0);
                rreg(8'h08, v); chk("R4 pending bit", v & 1, d > 0 ? 1 : 0);
            end
        end

        // R5: debounce run restart, count 3
        begin
            int pat [6] = '{700, 700, 100, 700, 700, 700};
            int exp [6] = '{0, 0, 0, 0, 0, 1};
            do_reset();
            code_q[0] = pat[0];
            wreg(8'h30, 600); wreg(8'h14, 3);
            wreg(8'h0C, 30); wreg(8'h10, 30); wreg(8'h04, 1);
            wreg(8'h00, 32'h15);
            for (k = 0; k < 6; k++) begin
                wait_smp(1);
                chk("R5 debounce irq", irq, exp[k]);
                if (k < 5) code_q[0] = pat[k + 1];
            end
            // irq masked when enable clear
            wreg(8'h04, 0);
            #1 chk("R5 irq masked", irq, 0);
        end

        // R6: write-one-to-clear and set-wins collision
        do_reset();
        code_q[0] = 700;
        wreg(8'h30, 600); wreg(8'h14, 1);
        wreg(8'h0C, 40); wreg(8'h10, 40); wreg(8'h04, 1);
        wreg(8'h00, 32'h15);
        wait_smp(1);
        rreg(8'h08, v); chk("R6 pending set", v & 1, 1);
        wreg(8'h08, 0);
        rreg(8'h08, v); chk("R6 write zero keeps", v & 1, 1);
        wreg(8'h08, 1);
        rreg(8'h08, v); chk("R6 clear", v & 1, 0);
        clash = 1;
        wait_smp(1);
        rreg(8'h08, v); chk("R6 set wins over clear", v & 1, 1);
        chk("R6 irq after collision", irq, 1);

        // R7/R8/R9: level x routing sweep
        for (int pol = 0; pol < 2; pol++) begin
            for (int rt = 0; rt < 4; rt++) begin
                int inact;
                inact = pol ? 0 : 1;
                do_reset();
                code_q[0] = 700;
                wreg(8'h40, 650); wreg(8'h18, 3); wreg(8'h14, 1); wreg(8'h30, 600);
                wreg(8'h0C, 30); wreg(8'h10, 30);
                wreg(8'h04, ((rt & 1) << 4) | (((rt >> 1) & 1) << 8));
                wreg(8'h00, 32'h11 | (pol << 2));
                wait_smp(1);
                rreg(8'h08, v); chk("R7 warn count independent", v & 1, 1);
                chk("R7 not yet shut pin", shut_pin, inact);
                wait_smp(1);
                chk("R7 not yet shut rst", shut_rst, inact);
                wait_smp(1);
                chk("R8 R9 pin line", shut_pin, (rt & 1) ? pol : inact);
                chk("R8 R9 reset line", shut_rst, (rt & 2) ? pol : inact);
                code_q[0] = 100;
                wait_smp(1);
                chk("R7 latch pin", shut_pin, (rt & 1) ? pol : inact);
                chk("R7 latch rst", shut_rst, (rt & 2) ? pol : inact);
                rreg(8'h08, v); chk("R7 status bit", (v >> 4) & 1, 1);
            end
        end

        // R10: normal versus hot interval
        do_reset();
        code_q[0] = 100;
        wreg(8'h30, 600);
        wreg(8'h0C, 300); wreg(8'h10, 100);
        wreg(8'h00, 32'h15);
        wait_smp(3);
        sp_cold = req_t_last - req_t_prev;
        code_q[0] = 700;
        wait_smp(1);
        code_q[0] = 100;
        wait_smp(1);
        sp_hot = req_t_last - req_t_prev;
        chk("R10 interval difference", sp_cold - sp_hot, 200);
        wait_smp(1);
        chk("R10 back to normal", req_t_last - req_t_prev, sp_cold);

        // R11: slow converter, two channels
        do_reset();
        ack_delay = 4;
        code_q[0] = 321; code_q[2] = 654;
        wreg(8'h0C, 30); wreg(8'h10, 30);
        wreg(8'h00, 32'h55);
        base = n_smp;
        wait_smp(4);
        chk("R11 samples completed", n_smp - base, 4);
        rreg(8'h28, v); chk("R11 data ch2", v, 654);
        ack_delay = 0;

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule